// File: doc/BRIEF.md
# Hub RAM Window Qualifier

This block sits between a shared-memory arbiter and a physical RAM that is smaller than the 1 MB logical byte space. Each request carries a 20-bit byte address. The block sorts the address into one of three classes before the RAM enable is raised. Low addresses reach the RAM unchanged. The 64-byte vector block at the very top of the logical space folds onto the last 64 bytes of the physical RAM. Everything between those two is a dead hole. A plain decode would let a small RAM repeat across the whole space, so a stray write beyond the physical top could overwrite low memory; this block stops that.

Accesses are one long wide. The RAM-side port carries an enable, per-byte write strobes, a long index and the write data. The RAM's registered read data comes back one cycle after the request. The block returns it, or a forced zero for a hole read, so every address class has the same read latency. A status output reports the class of each request for observation.

Top module: `hub_window_gate`

## Requirements
- R1: An address below PHYS_BYTES-64 is direct. It raises `ram_en` in the same cycle, with `ram_addr` equal to the address divided by 4.
- R2: An address from 0xFFFC0 to 0xFFFFF is a vector access. It raises `ram_en` with `ram_addr` = PHYS_BYTES/4 - 16 + address bits [5:2], which lands in the last 16 longs of the RAM.
- R3: An address from PHYS_BYTES-64 to 0xFFFBF is a hole. It never raises `ram_en` and never drives any bit of `ram_we`.
- R4: A hole read returns 0x00000000 on `rdata` one cycle after the request.
- R5: A direct or vector read returns the RAM's read data on `rdata` one cycle after the request.
- R6: A write to a direct or vector address drives `ram_we` equal to `be`, with bit n enabling byte lane n (bits 8n+7..8n). A read request drives `ram_we` to zero.
- R7: `acc_class` encodes the class as 0 for no request, 1 for direct, 2 for vector and 3 for hole.
- R8: A write to the hole leaves all RAM contents unchanged, including the locations that plain decoding would alias it onto.
- R9: While `req` is low, `ram_en` is low and `ram_we` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request for this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | 4 | Byte enables for writes |
| addr | input | 20 | Logical byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the request |
| acc_class | output | 2 | Class of the current request |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 4 | RAM per-byte write strobes |
| ram_addr | output | RAM_AW (13 by default) | RAM long index |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM registered read data |

## Verification
The enable, strobes, long index and class are combinational on the request. The bench checks them 1 ns after it drives the inputs, inside the same cycle. Read data is due one clock later. So each read pushes its expected long into a queue when it is issued, and a monitor pops and compares it at the falling edge that follows the capturing rising edge. Each hole read comes straight after a direct read, so stale RAM output would be visible if the zero substitution slipped by a cycle.

// File: rtl/hubwin_pkg.sv
package hubwin_pkg;
   // Access classes reported on acc_class
   typedef enum logic [1:0] {
      HW_IDLE   = 2'd0,
      HW_DIRECT = 2'd1,
      HW_VECTOR = 2'd2,
      HW_HOLE   = 2'd3
   } hw_region_e;
endpackage

// File: rtl/hubwin_classify.sv
// Sorts a logical byte address into direct, vector or hole.
module hubwin_classify
   import hubwin_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int PHYS_BYTES = 32768,
   parameter int VEC_BYTES  = 64
) (
   input  logic [ADDR_W-1:0] addr,
   output hw_region_e        cls
);
   localparam logic [ADDR_W:0] SPACE_BYTES = (ADDR_W+1)'(1) << ADDR_W;
   localparam logic [ADDR_W:0] VEC_START   = SPACE_BYTES - (ADDR_W+1)'(VEC_BYTES);
   localparam logic [ADDR_W:0] DIRECT_END  = (ADDR_W+1)'(PHYS_BYTES - VEC_BYTES);

   logic in_vec;
   assign in_vec = {1'b0, addr} >= VEC_START;

   generate
      if (PHYS_BYTES == (1 << ADDR_W)) begin : g_full
         // RAM fills the whole space: no hole exists
         always_comb cls = in_vec ? HW_VECTOR : HW_DIRECT;
      end else begin : g_part
         logic in_direct;
         assign in_direct = {1'b0, addr} < DIRECT_END;
         always_comb begin
            if (in_vec)         cls = HW_VECTOR;
            else if (in_direct) cls = HW_DIRECT;
            else                cls = HW_HOLE;
         end
      end
   endgenerate
endmodule

// File: rtl/hubwin_strobe.sv
// Gates enable and byte strobes by class and forms the RAM long index.
module hubwin_strobe
   import hubwin_pkg::*;
#(
   parameter int BE_W   = 4,
   parameter int RAM_AW = 13
) (
   input  logic              req,
   input  logic              wr,
   input  logic [BE_W-1:0]   be,
   input  hw_region_e        cls,
   input  logic [RAM_AW-1:0] word_idx,
   output logic              ram_en,
   output logic [BE_W-1:0]   ram_we,
   output logic [RAM_AW-1:0] ram_addr
);
   logic live;
   assign live = req && (cls != HW_HOLE);

   always_comb begin
      ram_en = live;
      ram_we = (live && wr) ? be : '0;
   end

   // The RAM size is a power of two, so the low bits of a vector address
   // already point into the top 64 bytes of the RAM; one slice serves both.
   assign ram_addr = word_idx;
endmodule

// File: rtl/hubwin_rdmask.sv
// Registers the hole-read flag so the zero lines up with RAM read latency.
module hubwin_rdmask #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hole_rd,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] rdata
);
   logic zero_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zero_q <= 1'b0;
      else        zero_q <= hole_rd;
   end

   assign rdata = zero_q ? '0 : ram_rdata;
endmodule

// File: rtl/hub_window_gate.sv
module hub_window_gate
   import hubwin_pkg::*;
#(
   parameter  int ADDR_W     = 20,
   parameter  int DATA_W     = 32,
   parameter  int PHYS_BYTES = 32768,
   parameter  int VEC_BYTES  = 64,
   localparam int BE_W       = DATA_W / 8,
   localparam int RAM_AW     = $clog2(PHYS_BYTES) - $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [BE_W-1:0]   be,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        acc_class,
   output logic              ram_en,
   output logic [BE_W-1:0]   ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata
);
   localparam int WORD_LSB = $clog2(BE_W);
   localparam int PHYS_AW  = $clog2(PHYS_BYTES);

   initial begin : p_param_check
      assert ((PHYS_BYTES & (PHYS_BYTES - 1)) == 0 && PHYS_BYTES >= 1024
              && PHYS_BYTES <= (1 << ADDR_W))
         else $error("PHYS_BYTES must be a power of two from 1 KB to the space size");
      assert (DATA_W >= 8 && (DATA_W & (DATA_W - 1)) == 0)
         else $error("DATA_W must be a power of two of at least 8");
      assert (VEC_BYTES >= BE_W && VEC_BYTES < PHYS_BYTES
              && (VEC_BYTES & (VEC_BYTES - 1)) == 0)
         else $error("VEC_BYTES must be a power of two inside the RAM");
   end

   hw_region_e cls;

   hubwin_classify #(
      .ADDR_W     (ADDR_W),
      .PHYS_BYTES (PHYS_BYTES),
      .VEC_BYTES  (VEC_BYTES)
   ) u_cls (
      .addr (addr),
      .cls  (cls)
   );

   hubwin_strobe #(
      .BE_W   (BE_W),
      .RAM_AW (RAM_AW)
   ) u_stb (
      .req      (req),
      .wr       (wr),
      .be       (be),
      .cls      (cls),
      .word_idx (addr[PHYS_AW-1:WORD_LSB]),
      .ram_en   (ram_en),
      .ram_we   (ram_we),
      .ram_addr (ram_addr)
   );

   hubwin_rdmask #(
      .DATA_W (DATA_W)
   ) u_rdm (
      .clk       (clk),
      .rst_n     (rst_n),
      .hole_rd   (req && !wr && (cls == HW_HOLE)),
      .ram_rdata (ram_rdata),
      .rdata     (rdata)
   );

   assign ram_wdata = wdata;
   assign acc_class = req ? 2'(cls) : 2'(HW_IDLE);
endmodule

// File: rtl/hubwin_chk.sv
module hubwin_chk #(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 32,
   parameter int PHYS_BYTES = 32768,
   parameter int VEC_BYTES  = 64,
   parameter int BE_W       = 4,
   parameter int RAM_AW     = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              wr,
   input logic [BE_W-1:0]   be,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rdata,
   input logic [1:0]        acc_class,
   input logic              ram_en,
   input logic [BE_W-1:0]   ram_we,
   input logic [RAM_AW-1:0] ram_addr,
   input logic [DATA_W-1:0] ram_rdata
);
   localparam int WORD_LSB = $clog2(BE_W);
   localparam logic [RAM_AW:0] VEC_BASE = (RAM_AW+1)'((PHYS_BYTES - VEC_BYTES) / BE_W);

   // R3: hole never reaches the RAM
   a_r3_hole_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_class == 2'd3) |-> (!ram_en && ram_we == '0));

   // R9: quiet when idle
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> (!ram_en && ram_we == '0));

   // R4: hole read returns zero one cycle later
   a_r4_hole_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !wr && acc_class == 2'd3) |=> (rdata == '0));

   // R5: valid read passes RAM data one cycle later
   a_r5_read_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !wr && acc_class != 2'd3) |=> (rdata == ram_rdata));

   // R6: reads assert no strobes; valid writes pass byte enables
   a_r6_read_no_we: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !wr) |-> (ram_we == '0));
   a_r6_write_be: assert property (@(posedge clk) disable iff (!rst_n)
      (req && wr && acc_class != 2'd3) |-> (ram_we == be && ram_en));

   // R2: vector accesses land in the top longs of the RAM
   a_r2_vector_top: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_class == 2'd2) |-> (ram_en && {1'b0, ram_addr} >= VEC_BASE));

   // R1: direct accesses use the long index of the address
   a_r1_direct_index: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_class == 2'd1) |-> (ram_en
         && ram_addr == RAM_AW'(addr >> WORD_LSB)));
endmodule

bind hub_window_gate hubwin_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .PHYS_BYTES (PHYS_BYTES),
   .VEC_BYTES  (VEC_BYTES),
   .BE_W       (BE_W),
   .RAM_AW     (RAM_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .wr        (wr),
   .be        (be),
   .addr      (addr),
   .rdata     (rdata),
   .acc_class (acc_class),
   .ram_en    (ram_en),
   .ram_we    (ram_we),
   .ram_addr  (ram_addr),
   .ram_rdata (ram_rdata)
);

// File: tb/sim_hub_window_gate.sv
`timescale 1ns/1ps
module sim_hub_window_gate;
   localparam int PHYS  = 4096;
   localparam int WORDS = PHYS / 4;
   localparam int AW    = $clog2(PHYS) - 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, wr = 1'b0;
   logic [3:0]  be = '0;
   logic [19:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  acc_class;
   logic        ram_en;
   logic [3:0]  ram_we;
   logic [AW-1:0] ram_addr;
   logic [31:0] ram_wdata;
   logic [31:0] ram_rdata = '0;

   int nchk = 0, nerr = 0;
   logic [31:0] mem  [WORDS];
   logic [31:0] refm [WORDS];
   logic [31:0] exp_q[$];
   string       tag_q[$];
   bit          due = 1'b0;

   always #10 clk = ~clk;

   hub_window_gate #(.PHYS_BYTES(PHYS)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .be(be), .addr(addr),
      .wdata(wdata), .rdata(rdata), .acc_class(acc_class), .ram_en(ram_en),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata));

   // RAM model: registered read, byte-lane writes
   always @(posedge clk) begin
      if (ram_en) begin
         for (int b = 0; b < 4; b++)
            if (ram_we[b]) mem[ram_addr][8*b +: 8] <= ram_wdata[8*b +: 8];
         if (ram_we == '0) ram_rdata <= mem[ram_addr];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int ref_class(input logic [19:0] a);
      if (a >= 20'hFFFC0) return 2;
      if (int'(a) < PHYS - 64) return 1;
      return 3;
   endfunction

   function automatic int ref_word(input logic [19:0] a);
      if (a >= 20'hFFFC0) return WORDS - 16 + int'(a[5:2]);
      return int'(a) / 4;
   endfunction

   task automatic access(input bit w, input logic [19:0] a, input logic [3:0] b,
                         input logic [31:0] d, input string tag);
      int c, wi;
      @(posedge clk); #2;
      req = 1'b1; wr = w; be = b; addr = a; wdata = d;
      #1;
      c  = ref_class(a);
      wi = ref_word(a);
      chk({tag, " R7 class"}, 32'(acc_class), 32'(c));
      chk({tag, " R3 en"}, 32'(ram_en), (c == 3) ? 32'd0 : 32'd1);
      chk({tag, " R6 we"}, 32'(ram_we), (w && c != 3) ? 32'(b) : 32'd0);
      if (c == 1) chk({tag, " R1 index"}, 32'(ram_addr), 32'(wi));
      if (c == 2) chk({tag, " R2 index"}, 32'(ram_addr), 32'(wi));
      if (!w) begin
         exp_q.push_back((c == 3) ? 32'd0 : refm[wi]);
         tag_q.push_back((c == 3) ? {tag, " R4 hole read"} : {tag, " R5 read"});
      end else if (c != 3) begin
         for (int k = 0; k < 4; k++)
            if (b[k]) refm[wi][8*k +: 8] = d[8*k +: 8];
      end
   endtask

   task automatic go_idle();
      @(posedge clk); #2;
      req = 1'b0; wr = 1'b0; be = '0;
   endtask

   // Scoreboard monitor: results due one cycle after a read is issued
   always @(negedge clk) begin
      if (due) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      due = rst_n && req && !wr;
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stim
      logic [19:0] holes [8];
      holes = '{20'h00FC0, 20'h00FFC, 20'h01000, 20'h01004,
                20'h08000, 20'h7FFC0, 20'hFFF80, 20'hFFFBC};
      for (int i = 0; i < WORDS; i++) begin mem[i] = '0; refm[i] = '0; end
      repeat (3) @(posedge clk);
      #5;
      // reset state (R9, R7)
      chk("reset R9 en", 32'(ram_en), 32'd0);
      chk("reset R9 we", 32'(ram_we), 32'd0);
      chk("reset R7 idle", 32'(acc_class), 32'd0);
      chk("reset R4 rdata", rdata, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // fill direct region (R1)
      for (int a = 0; a < PHYS - 64; a += 4)
         access(1'b1, 20'(a), 4'hF, 32'hD000_0000 | 32'(a), "wr direct R1");
      // fill vectors (R2)
      for (int a = 'hFFFC0; a <= 'hFFFFC; a += 4)
         access(1'b1, 20'(a), 4'hF, 32'hA5A5_0000 | 32'(a[15:0]), "wr vector R2");
      // hole writes must be dropped (R3, R8)
      foreach (holes[i])
         access(1'b1, holes[i], 4'hF, 32'hDEAD_BEEF, "wr hole R8");
      // partial byte write (R6): lanes 0 and 2
      access(1'b1, 20'h00010, 4'b0101, 32'h1122_3344, "wr partial R6");
      // read-only request with enables set must not strobe (R6)
      access(1'b0, 20'h00020, 4'hF, 32'hFFFF_FFFF, "rd be R6");
      go_idle();
      #1;
      chk("idle R9 en", 32'(ram_en), 32'd0);
      chk("idle R7 class", 32'(acc_class), 32'd0);

      // read back direct region (R5, R8 aliasing of word 0 etc.)
      for (int a = 0; a < PHYS - 64; a += 4)
         access(1'b0, 20'(a), 4'h0, '0, "rd direct R8");
      for (int a = 'hFFFC0; a <= 'hFFFFC; a += 4)
         access(1'b0, 20'(a), 4'h0, '0, "rd vector R2");
      // hole reads right after direct reads: stale RAM data must be masked (R4)
      foreach (holes[i]) begin
         access(1'b0, 20'h00100 + 20'(4 * i), 4'h0, '0, "rd pre R5");
         access(1'b0, holes[i], 4'h0, '0, "rd hole R4");
      end
      // top direct word next to the hole, and vector after hole
      access(1'b0, 20'(PHYS - 68), 4'h0, '0, "rd edge R1");
      access(1'b0, 20'(PHYS - 64), 4'h0, '0, "rd edge R3");
      access(1'b0, 20'hFFFFC, 4'h0, '0, "rd top R2");
      go_idle();
      repeat (3) @(posedge clk);
      #1;
      chk("end R9 we", 32'(ram_we), 32'd0);
      chk("end scoreboard drained", 32'(exp_q.size()), 32'd0);
      finish_run();
   end
endmodule